// File: doc/BRIEF.md
# Lens Barrel-Correction Source Address Pipeline

This block follows a video raster one pixel per clock. For each active output pixel it computes where that pixel must be read from in an uncorrected frame, so that a later fetch-and-interpolate stage can undo barrel distortion. Coordinates are signed and measured from the optical centre. A column counter and a row counter, each paired with a running square, move through the frame. The squares are kept by incremental addition, so the distance tracking needs no multiplier.

For each pixel the sum of the two squares is multiplied by a programmable coefficient and saturated into a scaled radius. The scaled radius addresses a 64-entry magnification curve, and the block interpolates linearly between neighbouring entries. The magnification then scales x and y in parallel. Results leave the block with a valid flag, three clock cycles after the pixel strobe. The pipeline never stalls. The curve lives in registers that are filled during reset. A frame marker and a line marker let the video timing realign the counters.

Top module: `lens_warp_addr`

## Requirements
- R1: While reset is asserted and just after it, `out_vld`, `out_x` and `out_y` are zero. The first pixel after reset is served at x = -COLS/2, y = -ROWS/2 (default -8, -6).
- R2: Every sampled `pix_vld` gives exactly one `out_vld` pulse, three rising edges later. A cycle without `pix_vld` gives no output pulse three edges later, and gaps between pixels are kept.
- R3: Each active pixel moves x up by one. Cycles with no pixel and no marker leave x and y unchanged.
- R4: After COLS active pixels of a line, the next pixel is served at x = -COLS/2 and at a y one greater than the previous line.
- R5: A `frame_go` cycle returns x, y and the column count to their start values for the next pixel. It takes priority over the line wrap in the same cycle. A pixel strobed in that cycle is still served with its own coordinates.
- R6: A `line_go` cycle returns x and the column count to the start of a line and leaves y unchanged.
- R7: The scaled radius is r = min((x² + y²)·k, 16383), 14 bits. Its upper 6 bits are the table index i and its lower 8 bits are the weight w.
- R8: The magnification, in unsigned Q1.15, is m = e(i) + floor((e(i+1) - e(i))·w / 256). Here e(j) = 32768 + 4·j², and e(64) takes the value of e(63).
- R9: `out_x` and `out_y` are x·m and y·m with 4 fractional bits, 17-bit signed. The product is scaled by 2^-11 and rounded to nearest, with halves rounded away from zero.
- R10: With k = 0 the magnification is exactly one, so each output equals its coordinate times 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; also fills the magnification curve |
| pix_vld | input | 1 | Active pixel strobe |
| line_go | input | 1 | Realign the column position to the start of a line |
| frame_go | input | 1 | Realign both coordinates to the top-left corner |
| coef_k | input | 8 | Unsigned distortion coefficient |
| out_vld | output | 1 | Corrected coordinate pair is valid |
| out_x | output | 17 | Corrected source x, signed, 4 fractional bits |
| out_y | output | 17 | Corrected source y, signed, 4 fractional bits |

## Verification
The delicate case is a frame marker that arrives in the same cycle as the last pixel of a line. Both the line wrap and the frame restart then want to load y. The bench runs a line up to its final column and strobes that pixel together with `frame_go`. It then checks that the next two pixels come out at the starting row, and not one row lower. It also checks that the colliding pixel itself still comes out with its own end-of-line coordinates, three edges later.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
   localparam int LUT_IDX_W = 6;
   localparam int LUT_N     = 1 << LUT_IDX_W;
   localparam int MAG_W     = 16;
   localparam int MAG_FRAC  = 15;
   localparam int MAG_ONE   = 1 << MAG_FRAC;

   // curve sample j: unity plus a quadratic rise; indices past the end clamp
   function automatic logic [MAG_W-1:0] curve_entry(input int j, input int curv);
      int jj;
      jj = (j > LUT_N - 1) ? LUT_N - 1 : j;
      return MAG_W'(MAG_ONE + curv * jj * jj);
   endfunction
endpackage

// File: rtl/lwa_axis_track.sv
module lwa_axis_track #(
   parameter int CW    = 12,
   parameter int SW    = 24,
   parameter int START = -8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 step,
   output logic signed [CW-1:0] coord,
   output logic        [SW-1:0] sq
);
   localparam logic signed [CW-1:0] C0 = CW'(START);
   localparam logic        [SW-1:0] S0 = SW'(START * START);

   logic [SW-1:0] c_ext;
   logic [SW-1:0] twice_plus1;
   logic [SW-1:0] sq_step;

   // (c+1)^2 = c^2 + 2c + 1, formed in two's complement modulo 2^SW
   assign c_ext       = {{(SW-CW){coord[CW-1]}}, coord};
   assign twice_plus1 = {c_ext[SW-2:0], 1'b1};
   assign sq_step     = sq + twice_plus1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coord <= C0;
         sq    <= S0;
      end else if (restart) begin
         coord <= C0;
         sq    <= S0;
      end else if (step) begin
         coord <= coord + CW'(1);
         sq    <= sq_step;
      end
   end
endmodule

// File: rtl/lwa_mag_lut.sv
module lwa_mag_lut
   import lwa_pkg::*;
#(
   parameter int WW   = 8,
   parameter int CURV = 4,
   localparam int RW  = LUT_IDX_W + WW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RW-1:0]    radius,
   output logic [MAG_W-1:0] mag
);
   logic [MAG_W-1:0]     tbl [0:LUT_N];
   logic [LUT_IDX_W-1:0] idx;
   logic [LUT_IDX_W:0]   nidx;
   logic [MAG_W-1:0]     lo;
   logic [MAG_W-1:0]     hi;

   // curve registers are written once, during reset, and held afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j <= LUT_N; j++) tbl[j] <= curve_entry(j, CURV);
      end
   end

   assign idx  = radius[RW-1:WW];
   assign nidx = {1'b0, idx} + (LUT_IDX_W+1)'(1);
   assign lo   = tbl[{1'b0, idx}];
   assign hi   = tbl[nidx];

   generate
      if (WW == 0) begin : g_step
         logic unused_hi;
         assign unused_hi = ^hi;
         assign mag = lo;
      end else begin : g_interp
         logic [MAG_W-1:0]    delta;
         logic [WW-1:0]       wgt;
         logic [MAG_W+WW-1:0] scaled;
         assign wgt    = radius[WW-1:0];
         assign delta  = hi - lo;
         assign scaled = {{WW{1'b0}}, delta} * {{MAG_W{1'b0}}, wgt};
         assign mag    = lo + scaled[MAG_W+WW-1:WW];
      end
   endgenerate
endmodule

// File: rtl/lwa_round_mul.sv
module lwa_round_mul
   import lwa_pkg::*;
#(
   parameter int CW    = 12,
   parameter int OW    = 17,
   parameter int SHIFT = 11
) (
   input  logic signed [CW-1:0] coord,
   input  logic        [MAG_W-1:0] mag,
   output logic signed [OW-1:0] res
);
   localparam int PW = CW + MAG_W + 1;

   logic signed [PW-1:0] cx;
   logic signed [PW-1:0] mx;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] bias;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] shifted;

   assign cx   = PW'(coord);
   assign mx   = PW'($signed({1'b0, mag}));
   assign prod = cx * mx;
   // half away from zero: negative values get one less than half before the floor shift
   assign bias    = prod[PW-1] ? PW'((1 << (SHIFT-1)) - 1) : PW'(1 << (SHIFT-1));
   assign biased  = prod + bias;
   assign shifted = biased >>> SHIFT;
   assign res     = shifted[OW-1:0];
endmodule

// File: rtl/lens_warp_addr.sv
module lens_warp_addr
   import lwa_pkg::*;
#(
   parameter int COLS = 16,
   parameter int ROWS = 12,
   parameter int CW   = 12,
   parameter int KW   = 8,
   parameter int WW   = 8,
   parameter int CURV = 4,
   parameter int FO   = 4,
   localparam int OW  = CW + 1 + FO
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pix_vld,
   input  logic                 line_go,
   input  logic                 frame_go,
   input  logic [KW-1:0]        coef_k,
   output logic                 out_vld,
   output logic signed [OW-1:0] out_x,
   output logic signed [OW-1:0] out_y
);
   localparam int SW    = 2 * CW;
   localparam int RW    = LUT_IDX_W + WW;
   localparam int COLW  = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int SHIFT = MAG_FRAC - FO;
   localparam int PRW   = SW + KW + 1;
   localparam logic [PRW-1:0]  RMAX  = PRW'((1 << RW) - 1);
   localparam logic [COLW-1:0] LASTC = COLW'(COLS - 1);

   generate
      if (COLS < 2 || (COLS % 2) != 0) begin : g_bad_cols
         $error("COLS must be even and at least 2");
      end
      if (ROWS < 2 || (ROWS % 2) != 0) begin : g_bad_rows
         $error("ROWS must be even and at least 2");
      end
      if ((COLS / 2) >= (1 << (CW - 1)) || (ROWS / 2) >= (1 << (CW - 1))) begin : g_bad_cw
         $error("CW too narrow for the frame size");
      end
      if (FO < 0 || FO >= MAG_FRAC) begin : g_bad_fo
         $error("FO must lie below the magnification fraction width");
      end
      if (MAG_ONE + CURV * (LUT_N - 1) * (LUT_N - 1) >= (1 << MAG_W) || CURV < 0) begin : g_bad_curv
         $error("CURV drives the curve beyond Q1.15");
      end
   endgenerate

   // ---- scan position, three stages ahead of the output ----
   logic [COLW-1:0]        col_q;
   logic                   wrap;
   logic signed [CW-1:0]   x_c, y_c;
   logic        [SW-1:0]   sx_c, sy_c;

   assign wrap = pix_vld && (col_q == LASTC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    col_q <= '0;
      else if (frame_go || line_go)  col_q <= '0;
      else if (pix_vld)              col_q <= wrap ? '0 : col_q + COLW'(1);
   end

   lwa_axis_track #(.CW(CW), .SW(SW), .START(-(COLS / 2))) u_xtrk (
      .clk(clk), .rst_n(rst_n),
      .restart(frame_go || line_go || wrap), .step(pix_vld),
      .coord(x_c), .sq(sx_c));

   lwa_axis_track #(.CW(CW), .SW(SW), .START(-(ROWS / 2))) u_ytrk (
      .clk(clk), .rst_n(rst_n),
      .restart(frame_go), .step(wrap),
      .coord(y_c), .sq(sy_c));

   // ---- stage 1: scaled squared radius ----
   logic [SW:0]          rsum;
   logic [PRW-1:0]       rprod;
   logic                 v1;
   logic [RW-1:0]        r1;
   logic signed [CW-1:0] x1, y1;

   assign rsum  = {1'b0, sx_c} + {1'b0, sy_c};
   assign rprod = {{KW{1'b0}}, rsum} * {{(SW+1){1'b0}}, coef_k};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; r1 <= '0; x1 <= '0; y1 <= '0;
      end else begin
         v1 <= pix_vld;
         r1 <= (rprod > RMAX) ? RMAX[RW-1:0] : rprod[RW-1:0];
         x1 <= x_c;
         y1 <= y_c;
      end
   end

   // ---- stage 2: magnification from the interpolated curve ----
   logic [MAG_W-1:0]     mag_c, mag2;
   logic                 v2;
   logic signed [CW-1:0] c2 [2];

   lwa_mag_lut #(.WW(WW), .CURV(CURV)) u_lut (
      .clk(clk), .rst_n(rst_n), .radius(r1), .mag(mag_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2 <= 1'b0; mag2 <= '0; c2[0] <= '0; c2[1] <= '0;
      end else begin
         v2    <= v1;
         mag2  <= mag_c;
         c2[0] <= x1;
         c2[1] <= y1;
      end
   end

   // ---- stage 3: both axes scaled in parallel ----
   logic signed [OW-1:0] res_c [2];

   generate
      for (genvar a = 0; a < 2; a++) begin : g_axis
         lwa_round_mul #(.CW(CW), .OW(OW), .SHIFT(SHIFT)) u_mul (
            .coord(c2[a]), .mag(mag2), .res(res_c[a]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0; out_x <= '0; out_y <= '0;
      end else begin
         out_vld <= v2;
         out_x   <= res_c[0];
         out_y   <= res_c[1];
      end
   end
endmodule

// File: rtl/lwa_checker.sv
module lwa_checker
   import lwa_pkg::*;
#(
   parameter int CW      = 12,
   parameter int COLW    = 4,
   parameter int COLS    = 16,
   parameter int START_X = -8,
   parameter int START_Y = -6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pix_vld,
   input logic                 line_go,
   input logic                 frame_go,
   input logic                 out_vld,
   input logic [COLW-1:0]      col_q,
   input logic signed [CW-1:0] x_c,
   input logic signed [CW-1:0] y_c,
   input logic                 v2,
   input logic [MAG_W-1:0]     mag2
);
   localparam logic signed [CW-1:0] X0 = CW'(START_X);
   localparam logic signed [CW-1:0] Y0 = CW'(START_Y);
   localparam logic [COLW-1:0]      LC = COLW'(COLS - 1);

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |-> ##3 out_vld);

   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |-> ##3 !out_vld);

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && !frame_go && !line_go && col_q != LC)
      |=> (x_c - $past(x_c) == CW'(1)) && $stable(y_c));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_vld && !frame_go && !line_go) |=> $stable(x_c) && $stable(y_c));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && !frame_go && !line_go && col_q == LC)
      |=> (x_c == X0) && (y_c - $past(y_c) == CW'(1)));

   p_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> (x_c == X0) && (y_c == Y0) && (col_q == '0));

   p_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_go && !frame_go) |=> (x_c == X0) && (col_q == '0));

   p_mag_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      v2 |-> (mag2 >= MAG_W'(MAG_ONE)));
endmodule

bind lens_warp_addr lwa_checker #(
   .CW(CW), .COLW(COLW), .COLS(COLS),
   .START_X(-(COLS / 2)), .START_Y(-(ROWS / 2))
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_go(line_go),
   .frame_go(frame_go), .out_vld(out_vld), .col_q(col_q),
   .x_c(x_c), .y_c(y_c), .v2(v2), .mag2(mag2)
);

// File: tb/sim_lens_warp_addr.sv
`timescale 1ns/1ps
module sim_lens_warp_addr;
   localparam int COLS = 16;
   localparam int ROWS = 12;
   localparam int X0   = -(COLS / 2);
   localparam int Y0   = -(ROWS / 2);
   localparam int NV   = 5;
   // columns: coefficient, pixel count, idle cycles after each pixel
   localparam int VEC [NV][3] = '{
      '{0,   20, 0},
      '{3,   12, 2},
      '{40,  24, 0},
      '{255, 16, 1},
      '{1,   10, 0}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               pix_vld = 1'b0;
   logic               line_go = 1'b0;
   logic               frame_go = 1'b0;
   logic [7:0]         coef_k = '0;
   logic               out_vld;
   logic signed [16:0] out_x, out_y;

   lens_warp_addr u0 (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_go(line_go),
      .frame_go(frame_go), .coef_k(coef_k), .out_vld(out_vld),
      .out_x(out_x), .out_y(out_y));

   always #10 clk = ~clk;

   int    cyc = 0;
   int    nchk = 0, nfail = 0;
   int    iss = 0, rcv = 0;
   int    mx = X0, my = Y0, mcol = 0;
   bit    done = 1'b0;
   int    ex [512];
   int    ey [512];
   int    ecyc [512];
   string etag [512];

   always @(posedge clk) cyc++;

   function automatic int ent(input int j);
      int jj;
      jj = (j > 63) ? 63 : j;
      return 32768 + 4 * jj * jj;
   endfunction

   function automatic int emag(input int r);
      int i, w;
      i = r >> 8;
      w = r & 255;
      return ent(i) + (((ent(i + 1) - ent(i)) * w) >> 8);
   endfunction

   function automatic int eround(input int p);
      if (p >= 0) return (p + 1024) >>> 11;
      return -((-p + 1024) >>> 11);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pix(input int k, input bit fr, input bit ln, input string tag);
      int r, m;
      string t;
      bit wrapm;
      r = (mx * mx + my * my) * k;
      if (r > 16383) r = 16383;
      m = emag(r);
      t = tag;
      if (t == "") begin
         if (k == 0)                     t = "R10";
         else if (r == 16383)            t = "R7";
         else if (mcol == 0 && my != Y0) t = "R4";
         else                            t = "R3/R8/R9";
      end
      ex[iss] = eround(mx * m);
      ey[iss] = eround(my * m);
      etag[iss] = t;
      ecyc[iss] = cyc;
      iss++;
      coef_k = 8'(k); pix_vld = 1'b1; frame_go = fr; line_go = ln;
      wrapm = (mcol == COLS - 1);
      if (fr) begin
         mx = X0; my = Y0; mcol = 0;
      end else begin
         if (wrapm) my++;
         if (ln || wrapm) begin mx = X0; mcol = 0; end
         else begin mx++; mcol++; end
      end
      @(posedge clk); #1;
      pix_vld = 1'b0; frame_go = 1'b0; line_go = 1'b0;
   endtask

   task automatic mark(input bit fr, input bit ln);
      frame_go = fr; line_go = ln;
      if (fr) begin mx = X0; my = Y0; mcol = 0; end
      else if (ln) begin mx = X0; mcol = 0; end
      @(posedge clk); #1;
      frame_go = 1'b0; line_go = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   // output monitor: value and arrival cycle of every pulse
   always @(negedge clk) begin
      if (rst_n && !done && out_vld) begin
         if (rcv >= iss) begin
            check(1'b0, "R2 unexpected out_vld", 1, 0);
         end else begin
            check(int'(out_x) == ex[rcv], {etag[rcv], " out_x"}, int'(out_x), ex[rcv]);
            check(int'(out_y) == ey[rcv], {etag[rcv], " out_y"}, int'(out_y), ey[rcv]);
            check(cyc == ecyc[rcv] + 3, "R2 latency cycle", cyc, ecyc[rcv] + 3);
            rcv++;
         end
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", rcv, iss);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
      check(out_x == '0, "R1 out_x in reset", int'(out_x), 0);
      check(out_y == '0, "R1 out_y in reset", int'(out_y), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      check(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
      @(posedge clk); #1;

      // first pixel served from the start corner
      pix(5, 1'b0, 1'b0, "R1 first pixel");

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         for (int p = 0; p < VEC[v][1]; p++) begin
            pix(VEC[v][0], 1'b0, 1'b0, "");
            idle(VEC[v][2]);
         end
      end
      idle(6);
      check(rcv == iss, "R2 pulse count after vectors", rcv, iss);

      // R6: line marker mid-line keeps the row
      mark(1'b1, 1'b0);
      for (int p = 0; p < 5; p++) pix(20, 1'b0, 1'b0, "R5 after frame");
      mark(1'b0, 1'b1);
      for (int p = 0; p < 3; p++) pix(20, 1'b0, 1'b0, "R6 after line marker");
      idle(6);

      // R5: frame marker together with the last pixel of a line
      mark(1'b1, 1'b0);
      for (int p = 0; p < COLS - 1; p++) pix(9, 1'b0, 1'b0, "R3 line fill");
      pix(9, 1'b1, 1'b0, "R5 colliding pixel");
      pix(9, 1'b0, 1'b0, "R5 restart over wrap");
      pix(9, 1'b0, 1'b0, "R5 restart over wrap");
      idle(6);

      // R10: unity magnification at the far corner of a row
      for (int p = 0; p < 4; p++) pix(0, 1'b0, 1'b0, "R10 unity");
      idle(6);
      check(rcv == iss, "R2 pulse count at end", rcv, iss);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule